// File: doc/BRIEF.md
# Fractional Clock Divider Field Encoder

This block converts a requested divide ratio into the counter settings of a clock-primitive output divider. The ratio arrives as an integer part N and a fractional part F counted in eighths, so the effective ratio is N + F/8. The block answers with a high count, a low count, an odd-ratio edge bit, a bypass (no-count) bit, and, for fractional ratios, an enable bit, the fraction, two waveform correction flags and a fractional phase.

A configuration engine offers one ratio per cycle with a valid/ready handshake. Each accepted ratio produces a single registered result one clock later, marked by a one-cycle valid pulse. The result fields then hold until the next accepted ratio. The block flags ratios whose counts cannot be expressed in the count fields and clears every field for them.

Integer ratios split into a high phase and a low phase. An odd ratio gives its extra cycle to the low phase and sets the edge bit. Fractional ratios need the counts trimmed, and the trim depends on whether N is even and on whether F equals one eighth.

Top module: `frac_div_encoder`

## Requirements
- R1: While reset is held, `i_ready`, `o_valid` and every result field are 0. From the first clock edge after reset is released, `i_ready` is 1.
- R2: A ratio is accepted on a clock edge where `i_valid` and `i_ready` are both 1. `o_valid` is 1 in exactly the cycle after an accepted ratio and 0 otherwise. The result fields change only on an accepted ratio and hold between accepts.
- R3: N = 1 yields `o_nocount` = 1 and every other field 0, for any F.
- R4: For 2 ≤ N ≤ 126 with F = 0: `o_high` = floor(N/2), `o_low` = ceil(N/2), `o_edge` = N mod 2. The fraction enable, fraction, both waveform flags and phase are all 0.
- R5: For N ≥ 2 with F ≠ 0: `o_frac_en` = 1, `o_frac` = F, `o_edge` = N mod 2, and `o_high` = floor((N−1)/2). `o_wf_rise` = 1 exactly when N is even.
- R6: For N ≥ 2 with F ≠ 0: `o_low` = floor(N/2) when N is odd and F ≠ 1. Otherwise `o_low` = floor(N/2) − 1.
- R7: For N ≥ 2 with F ≠ 0: `o_wf_fall` = 1 when exactly one of "N is even" and "F = 1" holds, and also when N = 2 with F = 1.
- R8: For N ≥ 2 with F ≠ 0: `o_phase` = 4·(N mod 2) + floor(F/2). For N = 2 with F = 4 this gives `o_phase` = 2.
- R9: N = 0 (any F), and N = 127 with F = 0, set `o_err` = 1 with every other field 0. At most one of `o_err`, `o_nocount` and `o_frac_en` is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Ratio offered |
| i_ready | output | 1 | Ratio can be accepted |
| i_int | input | 7 | Integer part N of the ratio |
| i_frac | input | 3 | Fractional part F, in eighths |
| o_valid | output | 1 | One-cycle pulse: new result present |
| o_high | output | 6 | High-phase count |
| o_low | output | 6 | Low-phase count |
| o_edge | output | 1 | Odd-ratio edge bit |
| o_nocount | output | 1 | Divider bypass (ratio of one) |
| o_frac_en | output | 1 | Fractional mode enable |
| o_frac | output | 3 | Fraction in eighths |
| o_wf_rise | output | 1 | Rising waveform correction flag |
| o_wf_fall | output | 1 | Falling waveform correction flag |
| o_phase | output | 3 | Fractional phase |
| o_err | output | 1 | Ratio not representable |

## Verification
The bench applies integer ratios of both parities, including the largest legal value. This separates the high/low split and the edge bit from the fractional trims. Fractional ratios cover even and odd N, crossed with F = 1 and F ≠ 1, which exercises each branch of the low-count trim and the fall-flag rule; N = 2 with F = 1 isolates the special fall-flag case. Unity ratios with a nonzero fraction show that the bypass takes priority. Zero and over-range ratios exercise the error path, and idle gaps and back-to-back offers exercise the pulse and hold timing.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Default field widths shared by the encoder and its checker.
  localparam int unsigned FDE_CNT_W  = 6;
  localparam int unsigned FDE_FRAC_W = 3;

  // Which rule set shapes the result for one ratio.
  typedef enum logic [1:0] {
    FDE_ERR    = 2'd0,
    FDE_BYPASS = 2'd1,
    FDE_INT    = 2'd2,
    FDE_FRAC   = 2'd3
  } fde_mode_e;

endpackage

// File: rtl/fde_int_path.sv
module fde_int_path #(
  parameter int unsigned CNT_W = 6,
  localparam int unsigned INT_W = CNT_W + 1
) (
  input  logic [INT_W-1:0] n,
  output logic [CNT_W-1:0] high,
  output logic [INT_W-1:0] low_wide,
  output logic             edge_bit
);

  // Low phase takes the larger half; kept wide so range can be judged.
  function automatic logic [INT_W-1:0] half_up(input logic [INT_W-1:0] v);
    return v - (v >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] half_down(input logic [INT_W-1:0] v);
    return CNT_W'(v >> 1);
  endfunction

  always_comb begin
    high     = half_down(n);
    low_wide = half_up(n);
    edge_bit = n[0];
  end

endmodule

// File: rtl/fde_frac_path.sv
module fde_frac_path #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned FRAC_W = 3,
  localparam int unsigned INT_W = CNT_W + 1
) (
  input  logic [INT_W-1:0]  n,
  input  logic [FRAC_W-1:0] f,
  output logic [CNT_W-1:0]  high,
  output logic [CNT_W-1:0]  low,
  output logic              edge_bit,
  output logic              wf_rise,
  output logic              wf_fall,
  output logic [FRAC_W-1:0] phase
);

  logic is_even;
  logic f_is_one;
  logic n_is_two;

  function automatic logic [CNT_W-1:0] trim_high(input logic [INT_W-1:0] v,
                                                 input logic ev);
    logic [INT_W-1:0] h;
    h = (v >> 1) - INT_W'(ev);
    return CNT_W'(h);
  endfunction

  function automatic logic [CNT_W-1:0] trim_low(input logic [INT_W-1:0] v,
                                                input logic ev,
                                                input logic one);
    logic [INT_W-1:0] l;
    l = (v >> 1) - INT_W'(ev | one);
    return CNT_W'(l);
  endfunction

  always_comb begin
    is_even  = ~n[0];
    f_is_one = (f == FRAC_W'(1));
    n_is_two = (n == INT_W'(2));
    edge_bit = n[0];
    high     = trim_high(n, is_even);
    low      = trim_low(n, is_even, f_is_one);
    wf_rise  = is_even;
    wf_fall  = (is_even ^ f_is_one) | (n_is_two & f_is_one);
    // edge weighted by half the fraction range, plus half the fraction
    phase    = {edge_bit, f[FRAC_W-1:1]};
  end

endmodule

// File: rtl/fde_classify.sv
module fde_classify
  import frac_div_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned FRAC_W = 3,
  localparam int unsigned INT_W = CNT_W + 1,
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic [INT_W-1:0]  n,
  input  logic [FRAC_W-1:0] f,
  input  logic [INT_W-1:0]  int_low_wide,
  output fde_mode_e         mode
);

  logic zero_n;
  logic int_overflow;

  always_comb begin
    zero_n       = (n == '0);
    int_overflow = (f == '0) && (int_low_wide > INT_W'(CNT_MAX));
    if (zero_n || int_overflow)  mode = FDE_ERR;
    else if (n == INT_W'(1))     mode = FDE_BYPASS;
    else if (f == '0)            mode = FDE_INT;
    else                         mode = FDE_FRAC;
  end

endmodule

// File: rtl/frac_div_encoder.sv
module frac_div_encoder
  import frac_div_pkg::*;
#(
  parameter int unsigned CNT_W  = FDE_CNT_W,
  parameter int unsigned FRAC_W = FDE_FRAC_W,
  localparam int unsigned INT_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  output logic              i_ready,
  input  logic [INT_W-1:0]  i_int,
  input  logic [FRAC_W-1:0] i_frac,
  output logic              o_valid,
  output logic [CNT_W-1:0]  o_high,
  output logic [CNT_W-1:0]  o_low,
  output logic              o_edge,
  output logic              o_nocount,
  output logic              o_frac_en,
  output logic [FRAC_W-1:0] o_frac,
  output logic              o_wf_rise,
  output logic              o_wf_fall,
  output logic [FRAC_W-1:0] o_phase,
  output logic              o_err
);

  // Named internal events, visible to the bound checker.
  logic      ready_q;
  logic      accept;
  fde_mode_e mode;

  logic [CNT_W-1:0]  ip_high;
  logic [INT_W-1:0]  ip_low_wide;
  logic              ip_edge;

  logic [CNT_W-1:0]  fp_high;
  logic [CNT_W-1:0]  fp_low;
  logic              fp_edge;
  logic              fp_rise;
  logic              fp_fall;
  logic [FRAC_W-1:0] fp_phase;

  logic [CNT_W-1:0]  nx_high;
  logic [CNT_W-1:0]  nx_low;
  logic              nx_edge;
  logic              nx_nocount;
  logic              nx_frac_en;
  logic [FRAC_W-1:0] nx_frac;
  logic              nx_rise;
  logic              nx_fall;
  logic [FRAC_W-1:0] nx_phase;
  logic              nx_err;

  assign accept  = i_valid & ready_q;
  assign i_ready = ready_q;

  fde_int_path #(.CNT_W(CNT_W)) u_int (
    .n        (i_int),
    .high     (ip_high),
    .low_wide (ip_low_wide),
    .edge_bit (ip_edge)
  );

  fde_frac_path #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_frac (
    .n        (i_int),
    .f        (i_frac),
    .high     (fp_high),
    .low      (fp_low),
    .edge_bit (fp_edge),
    .wf_rise  (fp_rise),
    .wf_fall  (fp_fall),
    .phase    (fp_phase)
  );

  fde_classify #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_cls (
    .n            (i_int),
    .f            (i_frac),
    .int_low_wide (ip_low_wide),
    .mode         (mode)
  );

  always_comb begin
    nx_high    = '0;
    nx_low     = '0;
    nx_edge    = 1'b0;
    nx_nocount = 1'b0;
    nx_frac_en = 1'b0;
    nx_frac    = '0;
    nx_rise    = 1'b0;
    nx_fall    = 1'b0;
    nx_phase   = '0;
    nx_err     = 1'b0;
    unique case (mode)
      FDE_ERR:    nx_err     = 1'b1;
      FDE_BYPASS: nx_nocount = 1'b1;
      FDE_INT: begin
        nx_high = ip_high;
        nx_low  = CNT_W'(ip_low_wide);
        nx_edge = ip_edge;
      end
      FDE_FRAC: begin
        nx_high    = fp_high;
        nx_low     = fp_low;
        nx_edge    = fp_edge;
        nx_frac_en = 1'b1;
        nx_frac    = i_frac;
        nx_rise    = fp_rise;
        nx_fall    = fp_fall;
        nx_phase   = fp_phase;
      end
      default: nx_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      o_valid   <= 1'b0;
      o_high    <= '0;
      o_low     <= '0;
      o_edge    <= 1'b0;
      o_nocount <= 1'b0;
      o_frac_en <= 1'b0;
      o_frac    <= '0;
      o_wf_rise <= 1'b0;
      o_wf_fall <= 1'b0;
      o_phase   <= '0;
      o_err     <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      o_valid <= accept;
      if (accept) begin
        o_high    <= nx_high;
        o_low     <= nx_low;
        o_edge    <= nx_edge;
        o_nocount <= nx_nocount;
        o_frac_en <= nx_frac_en;
        o_frac    <= nx_frac;
        o_wf_rise <= nx_rise;
        o_wf_fall <= nx_fall;
        o_phase   <= nx_phase;
        o_err     <= nx_err;
      end
    end
  end

endmodule

// File: rtl/fde_checker.sv
module fde_checker #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned FRAC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              i_ready,
  input logic              o_valid,
  input logic [CNT_W-1:0]  o_high,
  input logic [CNT_W-1:0]  o_low,
  input logic              o_edge,
  input logic              o_nocount,
  input logic              o_frac_en,
  input logic [FRAC_W-1:0] o_frac,
  input logic              o_wf_rise,
  input logic              o_wf_fall,
  input logic [FRAC_W-1:0] o_phase,
  input logic              o_err
);

  logic [2*CNT_W+2*FRAC_W+6:0] fields;
  assign fields = {o_high, o_low, o_edge, o_nocount, o_frac_en, o_frac,
                   o_wf_rise, o_wf_fall, o_phase, o_err};

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> i_ready);

  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> o_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !o_valid);

  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> $stable(fields));

  a_r3_nocount_alone: assert property (@(posedge clk) disable iff (!rst_n)
    o_nocount |-> (o_high == '0 && o_low == '0 && !o_edge && o_phase == '0));

  a_r5_frac_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    o_frac_en |-> (o_frac != '0));

  a_r5_rise_even: assert property (@(posedge clk) disable iff (!rst_n)
    o_frac_en |-> (o_wf_rise == !o_edge));

  a_r8_phase_tracks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    o_frac_en |-> (o_phase[FRAC_W-1] == o_edge));

  a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_err, o_nocount, o_frac_en}));

  a_r9_err_clears_fields: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> (o_high == '0 && o_low == '0 && !o_edge && o_frac == '0 &&
               !o_wf_rise && !o_wf_fall));

endmodule

bind frac_div_encoder fde_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_fde_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .i_ready   (i_ready),
  .o_valid   (o_valid),
  .o_high    (o_high),
  .o_low     (o_low),
  .o_edge    (o_edge),
  .o_nocount (o_nocount),
  .o_frac_en (o_frac_en),
  .o_frac    (o_frac),
  .o_wf_rise (o_wf_rise),
  .o_wf_fall (o_wf_fall),
  .o_phase   (o_phase),
  .o_err     (o_err)
);

// File: tb/tb_frac_div_encoder.sv
module tb_frac_div_encoder;

  localparam int CW = 6;
  localparam int FW = 3;
  localparam int IW = CW + 1;
  localparam int RW = 2*CW + 2*FW + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_valid = 1'b0;
  logic i_ready;
  logic [IW-1:0] i_int = '0;
  logic [FW-1:0] i_frac = '0;
  logic o_valid;
  logic [CW-1:0] o_high, o_low;
  logic o_edge, o_nocount, o_frac_en, o_wf_rise, o_wf_fall, o_err;
  logic [FW-1:0] o_frac, o_phase;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frac_div_encoder dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
    .i_int(i_int), .i_frac(i_frac), .o_valid(o_valid), .o_high(o_high),
    .o_low(o_low), .o_edge(o_edge), .o_nocount(o_nocount),
    .o_frac_en(o_frac_en), .o_frac(o_frac), .o_wf_rise(o_wf_rise),
    .o_wf_fall(o_wf_fall), .o_phase(o_phase), .o_err(o_err)
  );

  // Packed order: high, low, edge, nocount, frac_en, frac, rise, fall, phase, err
  function automatic logic [RW-1:0] got();
    return {o_high, o_low, o_edge, o_nocount, o_frac_en, o_frac,
            o_wf_rise, o_wf_fall, o_phase, o_err};
  endfunction

  // Expected fields restated from the requirements.
  function automatic logic [RW-1:0] expect_of(input int n, input int f);
    int hi, lo, ed, noc, fe, fr, ri, fa, ph, er;
    bit even;
    hi = 0; lo = 0; ed = 0; noc = 0; fe = 0; fr = 0; ri = 0; fa = 0; ph = 0; er = 0;
    even = (n % 2 == 0);
    if (n == 0 || (n == 127 && f == 0)) er = 1;        // R9
    else if (n == 1) noc = 1;                          // R3
    else if (f == 0) begin                             // R4
      hi = n / 2; lo = (n + 1) / 2; ed = n % 2;
    end else begin                                     // R5..R8
      fe = 1; fr = f; ed = n % 2;
      hi = (n - 1) / 2;
      lo = (!even && f != 1) ? n / 2 : n / 2 - 1;
      ri = even ? 1 : 0;
      fa = ((even && f != 1) || (!even && f == 1) || (n == 2 && f == 1)) ? 1 : 0;
      ph = ed * 4 + f / 2;
    end
    return {CW'(hi), CW'(lo), 1'(ed), 1'(noc), 1'(fe), FW'(fr),
            1'(ri), 1'(fa), FW'(ph), 1'(er)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offer one ratio; return at the negedge where the result is registered.
  task automatic offer(input int n, input int f);
    @(negedge clk);
    i_valid = 1'b1; i_int = IW'(n); i_frac = FW'(f);
    @(negedge clk);
    i_valid = 1'b0;
  endtask

  task automatic offer_check(input string req, input int n, input int f);
    offer(n, f);
    check({req, " valid"}, 32'(o_valid), 32'd1);
    check({req, " fields"}, 32'(got()), 32'(expect_of(n, f)));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(i_ready), 32'd0);
    check("R1 valid in reset", 32'(o_valid), 32'd0);
    check("R1 fields in reset", 32'(got()), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(i_ready), 32'd1);
  endtask

  task automatic t_integer();
    int vals[5] = '{2, 3, 10, 63, 126};
    foreach (vals[k]) offer_check("R4 integer", vals[k], 0);
  endtask

  task automatic t_unity();
    offer_check("R3 unity f0", 1, 0);
    offer_check("R3 unity f5", 1, 5);
  endtask

  task automatic t_fraction();
    int ns[10] = '{2, 2, 3, 3, 8, 8, 9, 9, 127, 127};
    int fs[10] = '{1, 4, 1, 6, 1, 7, 3, 2, 1, 5};
    for (int k = 0; k < 10; k++) offer_check("R5 R6 R7 R8 fraction", ns[k], fs[k]);
    offer(2, 1);
    check("R7 fall at N2 F1", 32'(o_wf_fall), 32'd1);
    offer(2, 4);
    check("R8 phase N2 F4", 32'(o_phase), 32'd2);
    offer(8, 3);
    check("R6 low even", 32'(o_low), 32'd3);
    offer(9, 3);
    check("R6 low odd", 32'(o_low), 32'd4);
  endtask

  task automatic t_error();
    offer_check("R9 zero", 0, 0);
    offer_check("R9 zero frac", 0, 3);
    offer_check("R9 overrange", 127, 0);
  endtask

  task automatic t_hold();
    logic [RW-1:0] snap;
    offer(5, 3);
    snap = got();
    i_int = IW'(20); i_frac = FW'(1);
    repeat (3) begin
      @(negedge clk);
      check("R2 valid low idle", 32'(o_valid), 32'd0);
      check("R2 fields hold", 32'(got()), 32'(snap));
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    i_valid = 1'b1; i_int = IW'(6); i_frac = FW'(0);
    @(negedge clk);
    check("R2 b2b first valid", 32'(o_valid), 32'd1);
    check("R2 b2b first", 32'(got()), 32'(expect_of(6, 0)));
    i_int = IW'(7); i_frac = FW'(1);
    @(negedge clk);
    i_valid = 1'b0;
    check("R2 b2b second valid", 32'(o_valid), 32'd1);
    check("R2 b2b second", 32'(got()), 32'(expect_of(7, 1)));
    @(negedge clk);
    check("R2 pulse ends", 32'(o_valid), 32'd0);
  endtask

  initial begin
    t_reset();
    t_integer();
    t_unity();
    t_fraction();
    t_error();
    t_hold();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule